// File: doc/BRIEF.md
# Console Deposit Microsequencer

This block performs the operator's deposit action as a short microprogram. When a deposit is requested, the word on the manual data switches is put on a parallel input bus and captured in a shift register. The shift register is then streamed one bit per clock, least significant bit first, into the word memory at the location the program counter points to. The program counter then advances by one, and the sequence ends with a one-cycle end indication and a halt. A second request, for setting the address, copies an address word into the program counter. The operator uses it to choose where the next deposit lands.

Requests are sampled into a register before they reach the sequencer, and a fixed priority chooses the entry point. The microcode words are computed by a function. Each word carries an X-source select, a miscellaneous control code, a memory write flag, an end flag, and a branch field. When a step does not branch, the low bits of the branch field also select the parallel-bus source. The memory has a combinational read port, so the stored contents can be inspected.

Top module: `deposit_panel_top`

## Requirements
- R1: After a synchronous reset, `pc_value` is 0, `busy` is 0 and `seq_end` is 0.
- R2: A deposit stores into memory, at the address in `pc_value`, the switch word sampled in the load step. The load step runs two clock edges after the edge that samples the request. Later changes of `sw_word` have no effect on the stored word.
- R3: A deposit that completes leaves `pc_value` one higher, and the value wraps from 1023 to 0.
- R4: `seq_end` goes high 4+SW (21) clock edges after the edge that samples a deposit request, and it stays high for exactly one cycle. `busy` is high from the edge after the sampling edge until the cycle in which `seq_end` is high, and it is low in that cycle.
- R5: A set-address request loads `ir_addr` into `pc_value`, and `seq_end` rises 3 edges after the sampling edge. This sequence branches to the shared end step.
- R6: If both requests are sampled in the same cycle, the set-address request wins and the deposit request is dropped.
- R7: Requests that arrive while `busy` is high are ignored. They start no sequence and leave the PC and the memory unchanged.
- R8: A deposit writes only the one word at the current PC. The other words keep their contents.
- R9: The misc control codes are 1110 for loading S from the parallel bus, 0001 for loading the PC from `ir_addr`, 1001 for incrementing the PC and 0101 for taking the memory address from the PC. X-source code 011 selects the serial output of S. Every write step uses X-source 011 and misc code 0101. A step that loads from the parallel bus never branches.
- R10: The serial write sends bit k of the word in the k-th write cycle. The first write cycle is the third edge after the sampling edge, so after 8 write cycles the low 8 bits of the target word already equal those of the switch word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| dep_req | input | 1 | Deposit request |
| setpc_req | input | 1 | Set-address request |
| sw_word | input | SW (17) | Manual data switches |
| ir_addr | input | PC_W (10) | Address for the set-address operation |
| rd_addr | input | PC_W (10) | Read address for memory inspection |
| rd_word | output | SW (17) | Combinational memory read data |
| pc_value | output | PC_W (10) | Program counter |
| busy | output | 1 | Microsequence running |
| seq_end | output | 1 | One-cycle end indication |

## Verification
Every result has a fixed due time counted from the edge that samples a request. The microsequence starts one edge later, the parallel load follows one edge after that, and the 17 serial write edges come next. The PC increment and the end step take one edge each, so a deposit's `seq_end` is due 21 edges after sampling and a set-address's is due 3 edges after. The bench drives and samples on falling edges and counts them one by one. A request driven at falling edge 0 must therefore show `seq_end` at falling edge 22 (or 4 for set-address), and a mismatch in that count fails the check. The partial serial check is taken at falling edge 11, after the eighth write edge.

// File: rtl/deposit_pkg.sv
package deposit_pkg;

    localparam int UPC_W = 4;

    typedef enum logic [2:0] {
        XS_ZERO = 3'b000,
        XS_SREG = 3'b011
    } xsel_e;

    typedef enum logic [3:0] {
        MC_NONE  = 4'b0000,
        MC_LDPC  = 4'b0001,
        MC_MAPC  = 4'b0101,
        MC_INCPC = 4'b1001,
        MC_PLS   = 4'b1110
    } misc_e;

    // Parallel bus source codes, carried in baddr[1:0] when br_en is low
    localparam logic [1:0] PIB_NONE = 2'b00;
    localparam logic [1:0] PIB_SW   = 2'b01;

    localparam logic [UPC_W-1:0] ENTRY_DEP   = 4'd0;
    localparam logic [UPC_W-1:0] ENTRY_SETPC = 4'd4;
    localparam logic [UPC_W-1:0] STEP_END    = 4'd3;

    typedef struct packed {
        logic             br_en;
        logic [UPC_W-1:0] baddr;
        xsel_e            xsel;
        misc_e            misc;
        logic             wmem;
        logic             eoi;
    } uword_t;

    function automatic uword_t ucode_nop();
        uword_t w;
        w.br_en = 1'b0;
        w.baddr = '0;
        w.xsel  = XS_ZERO;
        w.misc  = MC_NONE;
        w.wmem  = 1'b0;
        w.eoi   = 1'b0;
        return w;
    endfunction

    function automatic uword_t ucode_at(input logic [UPC_W-1:0] a);
        uword_t w;
        w = ucode_nop();
        case (a)
            4'd0: begin
                w.misc  = MC_PLS;
                w.baddr = {{(UPC_W-2){1'b0}}, PIB_SW};
            end
            4'd1: begin
                w.xsel = XS_SREG;
                w.misc = MC_MAPC;
                w.wmem = 1'b1;
            end
            4'd2: w.misc = MC_INCPC;
            4'd3: w.eoi  = 1'b1;
            4'd4: begin
                w.misc  = MC_LDPC;
                w.br_en = 1'b1;
                w.baddr = STEP_END;
            end
            default: w.eoi = 1'b1;
        endcase
        return w;
    endfunction

    function automatic logic [1:0] pib_source(input uword_t w);
        return w.br_en ? PIB_NONE : w.baddr[1:0];
    endfunction

endpackage

// File: rtl/deposit_ucode_rom.sv
module deposit_ucode_rom
    import deposit_pkg::*;
(
    input  logic             valid,
    input  logic [UPC_W-1:0] upc,
    output uword_t           uw
);
    always_comb begin
        if (valid) uw = ucode_at(upc);
        else       uw = ucode_nop();
    end
endmodule

// File: rtl/deposit_sequencer.sv
module deposit_sequencer
    import deposit_pkg::*;
#(
    parameter int SW = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dep_req,
    input  logic             setpc_req,
    input  uword_t           uw,
    output logic             run,
    output logic [UPC_W-1:0] upc,
    output logic [$clog2(SW)-1:0] bit_idx,
    output logic             seq_end
);
    localparam int BW = $clog2(SW);
    localparam logic [BW-1:0] LAST_BIT = BW'(SW - 1);

    logic dep_q, set_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dep_q   <= 1'b0;
            set_q   <= 1'b0;
            run     <= 1'b0;
            upc     <= '0;
            bit_idx <= '0;
            seq_end <= 1'b0;
        end else begin
            dep_q   <= dep_req;
            set_q   <= setpc_req;
            seq_end <= 1'b0;
            if (!run) begin
                bit_idx <= '0;
                if (set_q) begin
                    run <= 1'b1;
                    upc <= ENTRY_SETPC;
                end else if (dep_q) begin
                    run <= 1'b1;
                    upc <= ENTRY_DEP;
                end
            end else if (uw.eoi) begin
                run     <= 1'b0;
                seq_end <= 1'b1;
            end else if (uw.wmem && bit_idx != LAST_BIT) begin
                bit_idx <= bit_idx + 1'b1;
            end else begin
                bit_idx <= '0;
                upc     <= uw.br_en ? uw.baddr : upc + 1'b1;
            end
        end
    end
endmodule

// File: rtl/deposit_datapath.sv
module deposit_datapath
    import deposit_pkg::*;
#(
    parameter int SW   = 17,
    parameter int PC_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  uword_t          uw,
    input  logic [SW-1:0]   sw_word,
    input  logic [PC_W-1:0] ir_addr,
    output logic [PC_W-1:0] pc,
    output logic [PC_W-1:0] mem_addr,
    output logic            mem_we,
    output logic            x_bit
);
    logic [SW-1:0] s_reg;
    logic [SW-1:0] pib;

    always_comb begin
        case (pib_source(uw))
            PIB_SW:  pib = sw_word;
            default: pib = '0;
        endcase
    end

    always_comb begin
        case (uw.xsel)
            XS_SREG: x_bit = s_reg[0];
            default: x_bit = 1'b0;
        endcase
    end

    assign mem_addr = (uw.misc == MC_MAPC) ? pc : ir_addr;
    assign mem_we   = uw.wmem;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_reg <= '0;
        end else if (uw.misc == MC_PLS) begin
            s_reg <= pib;
        end else if (uw.wmem && uw.xsel == XS_SREG) begin
            s_reg <= {1'b0, s_reg[SW-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else begin
            case (uw.misc)
                MC_LDPC:  pc <= ir_addr;
                MC_INCPC: pc <= pc + 1'b1;
                default:  pc <= pc;
            endcase
        end
    end
endmodule

// File: rtl/deposit_word_mem.sv
module deposit_word_mem #(
    parameter int SW   = 17,
    parameter int PC_W = 10
) (
    input  logic                  clk,
    input  logic                  we,
    input  logic [PC_W-1:0]       waddr,
    input  logic [$clog2(SW)-1:0] wbit_idx,
    input  logic                  wbit,
    input  logic [PC_W-1:0]       raddr,
    output logic [SW-1:0]         rdata
);
    localparam int DEPTH = 1 << PC_W;

    logic [SW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr][wbit_idx] <= wbit;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/deposit_panel_top.sv
module deposit_panel_top
    import deposit_pkg::*;
#(
    parameter int SW   = 17,
    parameter int PC_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            dep_req,
    input  logic            setpc_req,
    input  logic [SW-1:0]   sw_word,
    input  logic [PC_W-1:0] ir_addr,
    input  logic [PC_W-1:0] rd_addr,
    output logic [SW-1:0]   rd_word,
    output logic [PC_W-1:0] pc_value,
    output logic            busy,
    output logic            seq_end
);
    localparam int BW = $clog2(SW);

    logic             run;
    logic [UPC_W-1:0] upc;
    logic [BW-1:0]    bit_idx;
    uword_t           uw_cur;
    logic [PC_W-1:0]  mem_addr;
    logic             mem_we;
    logic             x_bit;

    deposit_sequencer #(.SW(SW)) u_seq (
        .clk(clk), .rst(rst), .dep_req(dep_req), .setpc_req(setpc_req),
        .uw(uw_cur), .run(run), .upc(upc), .bit_idx(bit_idx), .seq_end(seq_end)
    );

    deposit_ucode_rom u_rom (
        .valid(run), .upc(upc), .uw(uw_cur)
    );

    deposit_datapath #(.SW(SW), .PC_W(PC_W)) u_dp (
        .clk(clk), .rst(rst), .uw(uw_cur), .sw_word(sw_word), .ir_addr(ir_addr),
        .pc(pc_value), .mem_addr(mem_addr), .mem_we(mem_we), .x_bit(x_bit)
    );

    deposit_word_mem #(.SW(SW), .PC_W(PC_W)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_addr), .wbit_idx(bit_idx),
        .wbit(x_bit), .raddr(rd_addr), .rdata(rd_word)
    );

    assign busy = run;
endmodule

// File: rtl/deposit_panel_checker.sv
module deposit_panel_checker
    import deposit_pkg::*;
#(
    parameter int PC_W = 10
) (
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            seq_end,
    input logic [PC_W-1:0] pc_value,
    input uword_t          uw
);
    a_r4_end_single: assert property (@(posedge clk) disable iff (rst)
        seq_end |=> !seq_end);

    a_r4_end_idle: assert property (@(posedge clk) disable iff (rst)
        seq_end |-> !busy);

    a_r3_pc_step: assert property (@(posedge clk) disable iff (rst)
        (uw.misc == MC_INCPC) |=> (pc_value == $past(pc_value) + 1'b1));

    a_r3_pc_hold: assert property (@(posedge clk) disable iff (rst)
        (uw.misc != MC_INCPC && uw.misc != MC_LDPC) |=> $stable(pc_value));

    a_r9_write_select: assert property (@(posedge clk) disable iff (rst)
        uw.wmem |-> (uw.xsel == XS_SREG && uw.misc == MC_MAPC));

    a_r9_pib_no_branch: assert property (@(posedge clk) disable iff (rst)
        (uw.misc == MC_PLS) |-> !uw.br_en);

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (uw.misc == MC_NONE && !uw.wmem));
endmodule

bind deposit_panel_top deposit_panel_checker #(.PC_W(PC_W)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .seq_end(seq_end),
    .pc_value(pc_value), .uw(uw_cur)
);

// File: tb/deposit_panel_top_test.sv
module deposit_panel_top_test;
    localparam int SW   = 17;
    localparam int PC_W = 10;
    localparam int DEP_EDGES = 4 + SW;
    localparam int SET_EDGES = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            dep_req = 1'b0;
    logic            setpc_req = 1'b0;
    logic [SW-1:0]   sw_word = '0;
    logic [PC_W-1:0] ir_addr = '0;
    logic [PC_W-1:0] rd_addr = '0;
    logic [SW-1:0]   rd_word;
    logic [PC_W-1:0] pc_value;
    logic            busy;
    logic            seq_end;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    deposit_panel_top #(.SW(SW), .PC_W(PC_W)) uut (
        .clk(clk), .rst(rst), .dep_req(dep_req), .setpc_req(setpc_req),
        .sw_word(sw_word), .ir_addr(ir_addr), .rd_addr(rd_addr),
        .rd_word(rd_word), .pc_value(pc_value), .busy(busy), .seq_end(seq_end)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] peek_dummy(input logic [SW-1:0] v);
        return v;
    endfunction

    task automatic read_word(input logic [PC_W-1:0] a, output logic [SW-1:0] d);
        rd_addr = a;
        #1;
        d = rd_word;
    endtask

    // drive a request at a falling edge; return falling edges until seq_end
    task automatic run_req(input logic dep, input logic setp, output int edges);
        dep_req   = dep;
        setpc_req = setp;
        edges = 0;
        @(negedge clk);
        edges = 1;
        dep_req   = 1'b0;
        setpc_req = 1'b0;
        while (!seq_end && edges < 100) begin
            @(negedge clk);
            edges++;
        end
    endtask

    task automatic t_reset();
        check("R1 pc", 32'(pc_value), 0);
        check("R1 busy", 32'(busy), 0);
        check("R1 seq_end", 32'(seq_end), 0);
    endtask

    task automatic t_setpc(input logic [PC_W-1:0] a);
        int e;
        ir_addr = a;
        run_req(1'b0, 1'b1, e);
        check("R5 latency", 32'(e), SET_EDGES + 1);
        check("R5 pc", 32'(pc_value), 32'(a));
        @(negedge clk);
        check("R4 end one cycle (setpc)", 32'(seq_end), 0);
    endtask

    task automatic t_deposit(input logic [SW-1:0] v);
        int e;
        logic [PC_W-1:0] p0;
        logic [SW-1:0] d;
        p0 = pc_value;
        sw_word = v;
        run_req(1'b1, 1'b0, e);
        check("R4 latency", 32'(e), DEP_EDGES + 1);
        check("R4 busy low at end", 32'(busy), 0);
        check("R3 pc inc", 32'(pc_value), 32'(PC_W'(p0 + 1'b1)));
        read_word(p0, d);
        check("R2 stored word", 32'(d), 32'(v));
        @(negedge clk);
        check("R4 end one cycle", 32'(seq_end), 0);
    endtask

    task automatic t_serial_and_hold();
        logic [SW-1:0] d;
        logic [PC_W-1:0] p0;
        int k;
        p0 = pc_value;
        rd_addr = p0;
        sw_word = 17'h0A5C3;
        dep_req = 1'b1;
        @(negedge clk);            // n1
        dep_req = 1'b0;
        @(negedge clk);            // n2
        check("R4 busy after dispatch", 32'(busy), 1);
        @(negedge clk);            // n3, load done at E2
        sw_word = 17'h1FFFF;
        for (int i = 4; i <= 11; i++) @(negedge clk);
        d = rd_word;
        check("R10 low byte after 8 writes", 32'(d[7:0]), 32'h0C3);
        k = 11;
        while (!seq_end && k < 100) begin
            @(negedge clk);
            k++;
        end
        check("R2 switch change ignored", 32'(peek_dummy(rd_word)), 32'h0A5C3);
        @(negedge clk);
    endtask

    task automatic t_priority();
        int e;
        logic [PC_W-1:0] p0;
        logic [SW-1:0] d_before, d_after;
        p0 = pc_value;
        read_word(10'd77, d_before);
        ir_addr = 10'd77;
        sw_word = 17'h15555;
        run_req(1'b1, 1'b1, e);
        check("R6 setpc wins latency", 32'(e), SET_EDGES + 1);
        check("R6 pc", 32'(pc_value), 77);
        for (int i = 0; i < 30; i++) @(negedge clk);
        check("R6 deposit dropped busy", 32'(busy), 0);
        check("R6 deposit dropped pc", 32'(pc_value), 77);
        read_word(10'd77, d_after);
        check("R6 memory untouched", 32'(d_after), 32'(d_before));
        if (p0 == 10'd77) $display("note: pc already 77");
    endtask

    task automatic t_busy_ignore();
        int k;
        logic [SW-1:0] d;
        t_setpc(10'd200);
        t_deposit(17'h00001);      // mem[200], pc=201
        t_setpc(10'd200);
        sw_word = 17'h12345;
        dep_req = 1'b1;
        @(negedge clk);
        dep_req = 1'b0;
        for (int i = 0; i < 8; i++) @(negedge clk);
        dep_req = 1'b1;
        setpc_req = 1'b1;
        ir_addr = 10'd5;
        @(negedge clk);
        dep_req = 1'b0;
        setpc_req = 1'b0;
        k = 0;
        while (!seq_end && k < 100) begin
            @(negedge clk);
            k++;
        end
        for (int i = 0; i < 30; i++) @(negedge clk);
        check("R7 no second sequence busy", 32'(busy), 0);
        check("R7 pc single step", 32'(pc_value), 201);
        read_word(10'd201, d);
        check("R8 neighbour untouched", 32'(d), 32'h0AAAA);
        read_word(10'd200, d);
        check("R7 word stored once", 32'(d), 32'h12345);
    endtask

    initial begin
        logic [SW-1:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        // preset neighbour 201
        t_setpc(10'd201);
        t_deposit(17'h0AAAA);
        t_setpc(10'd10);
        t_deposit(17'h1F00F);
        t_deposit(17'h00000);
        t_deposit(17'h1FFFF);
        read_word(10'd10, d);
        check("R8 earlier word kept", 32'(d), 32'h1F00F);
        t_serial_and_hold();
        t_setpc(10'd1023);
        t_deposit(17'h13579);
        check("R3 wrap to zero", 32'(pc_value), 0);
        t_priority();
        t_busy_ignore();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #2000000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule